// File: doc/BRIEF.md
# Power-Management Timer with Byte-Wide I/O Window

This block keeps a free-running power-management timer and exposes it through a programmable 256-byte I/O window. The timer advances by one on every clock cycle in which the tick-enable input is high; the surrounding chip drives that input at the standard 3.579545 MHz power-management rate. Software reads the timer one byte at a time from four consecutive window offsets, with the least significant byte at the lowest of them.

Three configuration bytes set the block up. The control byte holds the window enable and the width select. The width select chooses between a narrow readback (24 bits by default, with the bits above read as zero) and the full 32-bit value. The page byte gives bits 15:8 of the window base. A third byte is fixed at 0x01.

The counter itself always counts at full width. Only the readback is masked. Every access is combinational and completes in the cycle of its strobe, with no wait states. So the block has no valid/ready handshake and nothing to back-pressure. All pins are plain control, address and data signals.

Top module: `pmt_timer`

## Requirements
- R1: After synchronous reset the counter is 0, the control byte (offset 0x41) and the page byte (offset 0x49) both read 0x00, and no I/O access hits the window.
- R2: The counter increases by exactly one at each rising clock edge where `tick_en` is high. It holds its value when `tick_en` is low.
- R3: An I/O read returns its data on `io_rdata`, and an access raises `io_hit`, combinationally in the same cycle as the strobe.
- R4: Window offsets 0x08, 0x09, 0x0A and 0x0B return timer bytes 0, 1, 2 and 3. Offset bits 1:0 select the byte, and byte 0 is the least significant.
- R5: When control bit 3 is 0, timer bits at and above NARROW_W (default 24) read back as 0. When control bit 3 is 1, all 32 bits are visible.
- R6: An I/O read or write hits when `io_addr[15:8]` equals the page byte, control bit 7 is 1 and the page byte is nonzero. Otherwise `io_hit` stays 0.
- R7: `io_rdata` is 0xFF for every read that is not a hit on offsets 0x08 to 0x0B. I/O writes to the window leave the counter unchanged.
- R8: Configuration offset 0x48 always reads 0x01. Writes to it are ignored.
- R9: Configuration offsets 0x41 and 0x49 read back the last byte written to them. Every other configuration offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer advance enable, one count per cycle |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | I/O write data (discarded) |
| io_rdata | output | 8 | I/O read data |
| io_hit | output | 1 | Access falls in the enabled window |

## Verification
The bench aims at the masking boundary by building the block with a 12-bit narrow width. Reaching that boundary takes only a few thousand ticks. A design that masked the wrong bits, or masked in wide mode, would show nonzero upper bytes where the narrow view must read zero, or zeros where the wide view must show count bits. The bench also opens and closes the window in three ways: clearing the enable, setting the page to zero, and moving the page while reading the old address. A decoder that ignored any one of these conditions would raise `io_hit` or return timer data where the result must be 0xFF. It also writes into the window and to the fixed byte 0x48. If either write were not discarded, later reads would show a disturbed count or a value other than 0x01.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int          IO_AW      = 16;
  localparam logic [7:0]  CTRL_OFS   = 8'h41;
  localparam logic [7:0]  FIXED_OFS  = 8'h48;
  localparam logic [7:0]  PAGE_OFS   = 8'h49;
  localparam logic [7:0]  FIXED_VAL  = 8'h01;
  localparam logic [7:0]  TMR_OFS    = 8'h08;
  localparam int          EN_BIT     = 7;
  localparam int          WIDE_BIT   = 3;
endpackage

// File: rtl/pmt_cfg_regs.sv
module pmt_cfg_regs
  import pmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       win_en,
  output logic       wide,
  output logic [7:0] page_q
);
  logic [7:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      page_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CTRL_OFS) ctrl_q <= cfg_wdata;
      if (cfg_addr == PAGE_OFS) page_q <= cfg_wdata;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      CTRL_OFS:  cfg_rdata = ctrl_q;
      FIXED_OFS: cfg_rdata = FIXED_VAL;
      PAGE_OFS:  cfg_rdata = page_q;
      default:   cfg_rdata = 8'h00;
    endcase
  end

  assign win_en = ctrl_q[EN_BIT];
  assign wide   = ctrl_q[WIDE_BIT];
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pmt_io_decode.sv
module pmt_io_decode
  import pmt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic             win_en,
  input  logic             wide,
  input  logic [7:0]       page_q,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             io_hit,
  output logic [7:0]       io_rdata
);
  localparam int NBYTES = CNT_W / 8;
  localparam int LB     = $clog2(NBYTES);

  logic [CNT_W-1:0] vis;
  logic [7:0]       lane [NBYTES];
  logic             page_ok;
  logic             tmr_sel;

  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    if (b < NARROW_W) begin : g_low
      assign vis[b] = cnt_q[b];
    end else begin : g_high
      assign vis[b] = cnt_q[b] & wide;
    end
  end

  for (genvar l = 0; l < NBYTES; l++) begin : g_lane
    assign lane[l] = vis[8*l +: 8];
  end

  assign page_ok  = win_en && (page_q != 8'h00) && (io_addr[IO_AW-1:8] == page_q);
  assign io_hit   = (io_rd || io_wr) && page_ok;
  assign tmr_sel  = (io_addr[7:LB] == TMR_OFS[7:LB]);
  assign io_rdata = (io_rd && io_hit && tmr_sel) ? lane[io_addr[LB-1:0]] : 8'hFF;
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
  import pmt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             io_hit
);
  logic             win_en;
  logic             wide;
  logic [7:0]       page_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wdata_unused;

  assign wdata_unused = ^io_wdata;

  pmt_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .win_en(win_en), .wide(wide), .page_q(page_q)
  );

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_q(cnt_q)
  );

  pmt_io_decode #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_dec (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr | (wdata_unused & 1'b0)),
    .win_en(win_en), .wide(wide), .page_q(page_q), .cnt_q(cnt_q),
    .io_hit(io_hit), .io_rdata(io_rdata)
  );
endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk
  import pmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             io_rd,
  input logic             io_wr,
  input logic [IO_AW-1:0] io_addr,
  input logic [7:0]       io_rdata,
  input logic             io_hit,
  input logic [7:0]       cfg_addr,
  input logic [7:0]       cfg_rdata,
  input logic             win_en,
  input logic             wide,
  input logic [7:0]       page_q,
  input logic [CNT_W-1:0] cnt_q
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) tick_en |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !tick_en |=> $stable(cnt_q)); // R2
  AST_DECODE_OFF: assert property (@(posedge clk) disable iff (rst) (!win_en || page_q == 8'h00) |-> !io_hit); // R6
  AST_UNDECODED_FF: assert property (@(posedge clk) disable iff (rst) (io_rd && !(io_hit && io_addr[7:2] == TMR_OFS[7:2])) |-> io_rdata == 8'hFF); // R7
  AST_FIXED_REG: assert property (@(posedge clk) disable iff (rst) (cfg_addr == FIXED_OFS) |-> cfg_rdata == FIXED_VAL); // R8
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (rst) (io_rd && io_hit && io_addr[7:0] == 8'h0B && !wide) |-> io_rdata == 8'h00); // R5
endmodule

bind pmt_timer pmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .io_rd(io_rd), .io_wr(io_wr),
  .io_addr(io_addr), .io_rdata(io_rdata), .io_hit(io_hit),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .win_en(win_en),
  .wide(wide), .page_q(page_q), .cnt_q(cnt_q)
);

// File: tb/sim_pmt_timer.sv
`timescale 1ns/1ps
module sim_pmt_timer;
  localparam int NW = 12;

  logic        clk = 0;
  logic        rst = 1;
  logic        tick_en = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 8'h41;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic        io_rd = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = 16'h0008;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        io_hit;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_cnt = 0;
  logic [7:0]  m_ctrl = 0;
  logic [7:0]  m_page = 0;

  always #2 clk = ~clk;

  pmt_timer #(.CNT_W(32), .NARROW_W(NW)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_hit(io_hit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ctrl = 0; m_page = 0;
    end else begin
      if (tick_en) m_cnt = m_cnt + 1;
      if (cfg_wr && cfg_addr == 8'h41) m_ctrl = cfg_wdata;
      if (cfg_wr && cfg_addr == 8'h49) m_page = cfg_wdata;
    end
  end

  // per-cycle comparison, inputs are stable here
  always @(negedge clk) begin
    logic        e_hit;
    logic [7:0]  e_rd;
    logic [7:0]  e_cfg;
    logic [31:0] v;
    string       t;
    e_hit = (io_rd || io_wr) && m_ctrl[7] && m_page != 0 && io_addr[15:8] == m_page;
    v = m_ctrl[3] ? m_cnt : (m_cnt & ((32'd1 << NW) - 1));
    e_rd = (io_rd && e_hit && io_addr[7:2] == 6'h02) ? 8'(v >> (8 * io_addr[1:0])) : 8'hFF;
    case (cfg_addr)
      8'h41: e_cfg = m_ctrl;
      8'h48: e_cfg = 8'h01;
      8'h49: e_cfg = m_page;
      default: e_cfg = 8'h00;
    endcase
    if (rst) t = "R1";
    else if (!e_hit) t = "R6";
    else if (io_addr[7:2] != 6'h02) t = "R7";
    else t = m_ctrl[3] ? "R4" : "R5";
    chk({t, " hit"}, 32'(io_hit), 32'(e_hit));
    chk({t, " rdata"}, 32'(io_rdata), 32'(e_rd));
    chk((cfg_addr == 8'h48) ? "R8 cfg" : (rst ? "R1 cfg" : "R9 cfg"), 32'(cfg_rdata), 32'(e_cfg));
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    step(); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    step(); cfg_wr = 0;
  endtask

  initial begin
    io_rd = 1;
    repeat (3) step();
    #1 chk("R1 reset hit", 32'(io_hit), 0);
    chk("R1 reset cfg", 32'(cfg_rdata), 0);
    rst = 0;
    cfg_write(8'h49, 8'h40);
    cfg_write(8'h41, 8'h80);
    cfg_write(8'h48, 8'h55);
    step(); cfg_addr = 8'h48; io_addr = 16'h4008;
    #1 chk("R8 fixed", 32'(cfg_rdata), 32'h01);
    chk("R3 same-cycle hit", 32'(io_hit), 1);
    chk("R3 same-cycle data", 32'(io_rdata), 0);
    step(); tick_en = 1;
    repeat (5) step();
    tick_en = 0;
    #1 chk("R2 five ticks", 32'(io_rdata), 5);
    step(); tick_en = 1;
    repeat (300) step();
    tick_en = 0; io_addr = 16'h4009;
    #1 chk("R4 byte1", 32'(io_rdata), 32'h01);
    step(); io_addr = 16'h4008;
    #1 chk("R4 byte0", 32'(io_rdata), 32'h31);
    // write into the window: no effect on the count
    step(); io_rd = 0; io_wr = 1; io_addr = 16'h4008; io_wdata = 8'hAA;
    step(); io_wr = 0; io_rd = 1;
    #1 chk("R7 write ignored", 32'(io_rdata), 32'h31);
    // run past the narrow boundary
    step(); tick_en = 1;
    repeat (5000) step();
    tick_en = 0;
    for (int w = 0; w < 2; w++) begin
      cfg_write(8'h41, w ? 8'h88 : 8'h80);
      for (int o = 0; o < 16; o++) begin
        step(); io_addr = {8'h40, 8'(o)};
      end
      step(); io_addr = 16'h40FF;
    end
    // window closed: enable off, then page zero
    cfg_write(8'h41, 8'h08);
    step(); io_addr = 16'h4008;
    #1 chk("R6 disabled", 32'(io_hit), 0);
    cfg_write(8'h41, 8'h88);
    cfg_write(8'h49, 8'h00);
    step(); io_addr = 16'h0008;
    #1 chk("R6 page zero", 32'(io_hit), 0);
    cfg_write(8'h49, 8'h12);
    step(); io_addr = 16'h4008;
    #1 chk("R6 old page", 32'(io_rdata), 32'hFF);
    step(); io_addr = 16'h120C;
    #1 chk("R7 undecoded", 32'(io_rdata), 32'hFF);
    // mixed sweep with width toggling
    for (int i = 0; i < 6000; i++) begin
      step();
      tick_en = (i % 3) != 0;
      io_addr = {(i % 5 == 0) ? 8'h40 : 8'h12, 8'(i % 16)};
      io_rd = (i % 7) != 0;
      io_wr = (i % 7) == 0;
      if (i % 1000 == 0) begin
        cfg_wr = 1; cfg_addr = 8'h41; cfg_wdata = 8'h80 | (8'((i / 1000) % 2) << 3);
      end else begin
        cfg_wr = 0; cfg_addr = 8'(i % 80);
      end
    end
    step(); cfg_wr = 0; tick_en = 0; io_wr = 0; io_rd = 0;
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule